// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the datapath half of a small accumulator machine. Every register in it is connected to one 8-bit internal bus. On each clock cycle, outside control logic picks one source to drive that bus and raises the load strobes of the registers that should capture it at the next rising edge. The registers are a 4-bit program counter, a 4-bit memory address register, an instruction register, an accumulator, an operand register and an output register. A 16-byte RAM and an add/subtract unit also sit on the bus.

The block does not sequence its own microcode. A controller, which in this project is the testbench, produces the fetch and execute steps. It reads the opcode nibble from the instruction register to choose the next step, and the output register value goes to a display. A preload port fills the RAM with a program before the run starts.

The address registers keep only the low nibble of the bus. The instruction register puts only its operand nibble back onto the bus. The arithmetic result reaches the bus combinationally, so an add or subtract finishes in the same cycle that writes it back.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears PC, MAR, IR, A, B and OUT at the rising edge. RAM contents are kept through reset.
- R2: `bus_src` selects the bus driver: 0 = none, 1 = PC, 2 = RAM, 3 = IR operand, 4 = A, 5 = ALU. Codes 0, 6 and 7 give a bus value of zero.
- R3: With `ld_pc` or `ld_mar` high, PC or MAR captures bus bits [3:0]. With `ld_ir` high, IR captures the whole bus byte, and `opcode` shows IR bits [7:4].
- R4: When IR drives the bus (code 3), bits [3:0] carry IR[3:0] and bits [7:4] are zero.
- R5: `pc_inc` adds one to PC modulo 16 at the edge. When `ld_pc` is also high, the load takes effect and the increment does not.
- R6: The ALU output is A+B when `alu_sub` is 0 and A−B when it is 1, modulo 256. It changes A only when it drives the bus while `ld_a` is high.
- R7: The RAM read value comes combinationally from the location that MAR addresses. With `ram_we` high, the bus value is written to that location at the edge.
- R8: `pre_we` writes `pre_data` to location `pre_addr` at the edge. In a cycle where `pre_we` is high, `ram_we` has no effect.
- R9: OUT loads the bus when `ld_out` is high and keeps its value in every other cycle. `out_val` always shows OUT.
- R10: A and B load the bus value with `ld_a` and `ld_b`. Any set of load strobes may be active in one cycle, and all of them capture the same bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_src | input | 3 | Bus driver select code |
| ld_pc | input | 1 | PC loads bus low nibble |
| pc_inc | input | 1 | PC counts up by one |
| ld_mar | input | 1 | MAR loads bus low nibble |
| ld_ir | input | 1 | IR loads bus byte |
| ld_a | input | 1 | Accumulator loads bus |
| ld_b | input | 1 | Operand register loads bus |
| ld_out | input | 1 | Output register loads bus |
| ram_we | input | 1 | RAM location at MAR is written from bus |
| alu_sub | input | 1 | 1 = subtract, 0 = add |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 4 | Preload address |
| pre_data | input | 8 | Preload data |
| opcode | output | 4 | Upper nibble of IR |
| out_val | output | 8 | Output register contents |

## Verification
The assertions take the select code and load strobes to be known, 0 or 1, in every cycle after reset. They allow any mix of strobes, including a PC load and a PC increment together and a preload at the same time as a bus write. The stimulus drives every control input at the falling edge, so all of them hold steady around each rising edge. The bench keeps `rst` high for the first edges, so no property looks at registers that have not yet been cleared. Unused select codes and the conflicting strobe pairs are driven on purpose, so those assertions are exercised as well.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_PC   = 3'd1;
  localparam logic [2:0] SRC_RAM  = 3'd2;
  localparam logic [2:0] SRC_IR   = 3'd3;
  localparam logic [2:0] SRC_ACC  = 3'd4;
  localparam logic [2:0] SRC_ALU  = 3'd5;

  typedef enum logic [2:0] {
    DRV_NONE = 3'd0,
    DRV_PC   = 3'd1,
    DRV_RAM  = 3'd2,
    DRV_IR   = 3'd3,
    DRV_ACC  = 3'd4,
    DRV_ALU  = 3'd5,
    DRV_RSV6 = 3'd6,
    DRV_RSV7 = 3'd7
  } bus_drv_e;

endpackage

// File: rtl/sbus_addr_reg.sv
module sbus_addr_reg #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter bit CAN_COUNT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              inc,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] q
);

  logic [ADDR_W-1:0] q_next;
  logic              unused_hi;

  assign unused_hi = ^bus_in[DATA_W-1:ADDR_W];

  generate
    if (CAN_COUNT) begin : g_count
      always_comb begin
        if (ld)       q_next = bus_in[ADDR_W-1:0];
        else if (inc) q_next = q + {{(ADDR_W-1){1'b0}}, 1'b1};
        else          q_next = q;
      end
    end else begin : g_plain
      logic unused_inc;
      assign unused_inc = inc;
      always_comb begin
        if (ld) q_next = bus_in[ADDR_W-1:0];
        else    q_next = q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

endmodule

// File: rtl/sbus_data_reg.sv
module sbus_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= bus_in;
  end

endmodule

// File: rtl/sbus_ram.sv
module sbus_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (pre_we)  cells[pre_addr] <= pre_data;
    else if (we) cells[addr]     <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] addsub(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z,
    input logic              minus
  );
    logic [DATA_W-1:0] zz;
    zz = minus ? ~z : z;
    return x + zz + {{(DATA_W-1){1'b0}}, minus};
  endfunction

  assign y = addsub(opa, opb, sub);

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               bus_src,
  input  logic                     ld_pc,
  input  logic                     pc_inc,
  input  logic                     ld_mar,
  input  logic                     ld_ir,
  input  logic                     ld_a,
  input  logic                     ld_b,
  input  logic                     ld_out,
  input  logic                     ram_we,
  input  logic                     alu_sub,
  input  logic                     pre_we,
  input  logic [ADDR_W-1:0]        pre_addr,
  input  logic [DATA_W-1:0]        pre_data,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic [DATA_W-1:0]        out_val
);
  import sbus_pkg::*;

  localparam int HI_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] bus_w;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] ram_rd;
  logic              ram_wr_fire;
  bus_drv_e          drv;

  assign drv         = bus_drv_e'(bus_src);
  assign ram_wr_fire = ram_we & ~pre_we;

  always_comb begin
    case (drv)
      DRV_PC:  bus_w = {{HI_W{1'b0}}, pc_q};
      DRV_RAM: bus_w = ram_rd;
      DRV_IR:  bus_w = {{HI_W{1'b0}}, ir_q[ADDR_W-1:0]};
      DRV_ACC: bus_w = a_q;
      DRV_ALU: bus_w = alu_y;
      default: bus_w = '0;
    endcase
  end

  sbus_addr_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAN_COUNT(1'b1)) pc_i (
    .clk(clk), .rst(rst), .ld(ld_pc), .inc(pc_inc), .bus_in(bus_w), .q(pc_q)
  );

  sbus_addr_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAN_COUNT(1'b0)) mar_i (
    .clk(clk), .rst(rst), .ld(ld_mar), .inc(1'b0), .bus_in(bus_w), .q(mar_q)
  );

  sbus_data_reg #(.DATA_W(DATA_W)) ir_i (
    .clk(clk), .rst(rst), .ld(ld_ir), .bus_in(bus_w), .q(ir_q)
  );

  sbus_data_reg #(.DATA_W(DATA_W)) acc_i (
    .clk(clk), .rst(rst), .ld(ld_a), .bus_in(bus_w), .q(a_q)
  );

  sbus_data_reg #(.DATA_W(DATA_W)) opb_i (
    .clk(clk), .rst(rst), .ld(ld_b), .bus_in(bus_w), .q(b_q)
  );

  sbus_data_reg #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .ld(ld_out), .bus_in(bus_w), .q(out_val)
  );

  sbus_alu #(.DATA_W(DATA_W)) alu_i (
    .opa(a_q), .opb(b_q), .sub(alu_sub), .y(alu_y)
  );

  sbus_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .addr(mar_q), .we(ram_wr_fire), .wdata(bus_w),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data), .rdata(ram_rd)
  );

  assign opcode = ir_q[DATA_W-1:ADDR_W];

endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_src,
  input logic              ld_pc,
  input logic              pc_inc,
  input logic              ld_mar,
  input logic              ld_a,
  input logic              ld_out,
  input logic              alu_sub,
  input logic [DATA_W-1:0] bus_w,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] mar_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [DATA_W-1:0] out_val
);
  import sbus_pkg::*;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && mar_q == '0 && ir_q == '0 && a_q == '0 && b_q == '0 && out_val == '0));

  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_src == SRC_NONE || bus_src > SRC_ALU) |-> bus_w == '0);

  a_r3_mar_low_nibble: assert property (@(posedge clk) disable iff (rst)
    ld_mar |=> mar_q == $past(bus_w[ADDR_W-1:0]));

  a_r4_ir_operand_only: assert property (@(posedge clk) disable iff (rst)
    bus_src == SRC_IR |-> (bus_w[DATA_W-1:ADDR_W] == '0 && bus_w[ADDR_W-1:0] == ir_q[ADDR_W-1:0]));

  a_r5_pc_counts: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !ld_pc) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> pc_q == $past(bus_w[ADDR_W-1:0]));

  a_r6_alu_writeback: assert property (@(posedge clk) disable iff (rst)
    (ld_a && bus_src == SRC_ALU) |=>
      a_q == ($past(alu_sub) ? $past(a_q) - $past(b_q) : $past(a_q) + $past(b_q)));

  a_r6_acc_holds: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(a_q));

  a_r9_out_holds: assert property (@(posedge clk) disable iff (rst)
    !ld_out |=> $stable(out_val));

  a_r9_out_loads: assert property (@(posedge clk) disable iff (rst)
    ld_out |=> out_val == $past(bus_w));

endmodule

bind sbus_datapath sbus_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_src(bus_src), .ld_pc(ld_pc), .pc_inc(pc_inc),
  .ld_mar(ld_mar), .ld_a(ld_a), .ld_out(ld_out), .alu_sub(alu_sub),
  .bus_w(bus_w), .pc_q(pc_q), .mar_q(mar_q), .ir_q(ir_q), .a_q(a_q),
  .b_q(b_q), .out_val(out_val)
);

// File: tb/sbus_datapath_tb.sv
`timescale 1ns/1ps
module sbus_datapath_tb_top;

  localparam int C_LDPC  = 1;
  localparam int C_INC   = 2;
  localparam int C_LDMAR = 4;
  localparam int C_LDIR  = 8;
  localparam int C_LDA   = 16;
  localparam int C_LDB   = 32;
  localparam int C_LDOUT = 64;
  localparam int C_WE    = 128;
  localparam int C_SUB   = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_src = 3'd0;
  logic ld_pc = 0, pc_inc = 0, ld_mar = 0, ld_ir = 0, ld_a = 0, ld_b = 0;
  logic ld_out = 0, ram_we = 0, alu_sub = 0, pre_we = 0;
  logic [3:0] pre_addr = 4'd0;
  logic [7:0] pre_data = 8'd0;
  logic [3:0] opcode;
  logic [7:0] out_val;

  int n_checks = 0;
  int n_fail   = 0;

  int m_mem [16];
  int m_pc, m_mar, m_ir, m_a, m_b, m_out;

  always #2.5 clk = ~clk;

  sbus_datapath dut_i (
    .clk(clk), .rst(rst), .bus_src(bus_src), .ld_pc(ld_pc), .pc_inc(pc_inc),
    .ld_mar(ld_mar), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_out(ld_out),
    .ram_we(ram_we), .alu_sub(alu_sub), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .opcode(opcode), .out_val(out_val)
  );

  function automatic int model_bus(input int src, input bit sub);
    case (src)
      1: return m_pc;
      2: return m_mem[m_mar];
      3: return m_ir % 16;
      4: return m_a;
      5: return sub ? (m_a - m_b + 256) % 256 : (m_a + m_b) % 256;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(input int src, input int ctl, input string tag,
                      input bit do_rst = 0, input bit pw = 0,
                      input int pa = 0, input int pd = 0);
    int bv;
    bus_src = src[2:0];
    ld_pc = (ctl & C_LDPC) != 0;  pc_inc = (ctl & C_INC) != 0;
    ld_mar = (ctl & C_LDMAR) != 0; ld_ir = (ctl & C_LDIR) != 0;
    ld_a = (ctl & C_LDA) != 0;    ld_b = (ctl & C_LDB) != 0;
    ld_out = (ctl & C_LDOUT) != 0; ram_we = (ctl & C_WE) != 0;
    alu_sub = (ctl & C_SUB) != 0;
    rst = do_rst; pre_we = pw; pre_addr = pa[3:0]; pre_data = pd[7:0];
    bv = model_bus(src, alu_sub);
    @(posedge clk);
    if (pw) m_mem[pa] = pd;
    else if (ram_we) m_mem[m_mar] = bv;
    if (do_rst) begin
      m_pc = 0; m_mar = 0; m_ir = 0; m_a = 0; m_b = 0; m_out = 0;
    end else begin
      if (ld_pc) m_pc = bv % 16; else if (pc_inc) m_pc = (m_pc + 1) % 16;
      if (ld_mar) m_mar = bv % 16;
      if (ld_ir)  m_ir = bv;
      if (ld_a)   m_a = bv;
      if (ld_b)   m_b = bv;
      if (ld_out) m_out = bv;
    end
    @(negedge clk);
    check({tag, " out"}, int'(out_val), m_out);
    check({tag, " opcode"}, int'(opcode), m_ir / 16);
  endtask

  task automatic fetch();
    step(1, C_LDMAR, "R3 fetch addr");
    step(2, C_LDIR | C_INC, "R7 fetch instr");
  endtask

  task automatic show_a(input string tag);
    step(4, C_LDOUT, tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    m_pc = 0; m_mar = 0; m_ir = 0; m_a = 0; m_b = 0; m_out = 0;
    @(negedge clk);
    step(0, 0, "R1 reset", 1);
    step(0, 0, "R1 reset", 1);

    // R8: preload program; one preload collides with ram_we
    step(0, 0, "R8 preload", 0, 1, 0, 8'h1E);
    step(0, 0, "R8 preload", 0, 1, 1, 8'h2F);
    step(0, 0, "R8 preload", 0, 1, 2, 8'hE0);
    step(0, C_WE, "R8 preload wins over ram_we", 0, 1, 3, 8'h3D);
    step(0, 0, "R8 preload", 0, 1, 4, 8'h4C);
    step(0, 0, "R8 preload", 0, 1, 13, 9);
    step(0, 0, "R8 preload", 0, 1, 14, 200);
    step(0, 0, "R8 preload", 0, 1, 15, 100);

    // LDA 14
    fetch();
    step(3, C_LDMAR, "R4 operand to MAR");
    step(2, C_LDA, "R10 ram to A");
    show_a("R10 A loaded");
    // ADD 15 -> 44 (wraps)
    fetch();
    step(3, C_LDMAR, "R4 operand to MAR");
    step(2, C_LDB, "R10 ram to B");
    step(5, C_LDA, "R6 add wraps");
    // OUT
    fetch();
    show_a("R6 sum 44 on OUT");
    // SUB 13 -> 35
    fetch();
    step(3, C_LDMAR, "R4 operand to MAR");
    step(2, C_LDB, "R10 ram to B");
    step(5, C_LDA | C_SUB, "R6 subtract");
    show_a("R6 diff 35 on OUT");
    // STA 12
    fetch();
    step(3, C_LDMAR, "R4 operand to MAR");
    step(4, C_WE, "R7 store A");
    step(2, C_LDOUT, "R7 read back stored");
    step(3, C_LDOUT, "R4 IR operand nibble on OUT");

    // R6: subtract wrap below zero, and ALU without ld_a
    step(4, C_LDB, "R10 A to B");
    step(5, C_LDA | C_SUB, "R6 A-B zero");
    step(5, C_LDOUT | C_SUB, "R6 ALU to OUT only");
    show_a("R6 A untouched without ld_a");
    step(5, C_LDA | C_LDOUT | C_SUB, "R10 multi-load negative wrap");

    // R2: idle and unused codes
    step(0, C_LDOUT, "R2 no driver zero");
    show_a("R9 restore");
    step(7, C_LDOUT, "R2 code 7 zero");
    step(6, C_LDB | C_LDOUT, "R2 code 6 zero");
    step(4, 0, "R9 holds without ld_out");
    step(2, 0, "R9 holds without ld_out");

    // R5: PC load, wrap and priority
    show_a("R9 A value");
    step(4, C_LDPC, "R3 PC low nibble");
    step(1, C_LDOUT, "R5 PC visible");
    step(0, C_INC, "R5 count");
    step(0, C_INC, "R5 count");
    step(0, C_INC, "R5 count wrap");
    step(1, C_LDOUT, "R5 PC wrapped");
    step(3, C_LDPC | C_INC, "R5 load beats count");
    step(1, C_LDOUT, "R5 PC loaded");

    // R7: memory at preload/ram_we collision address kept preload value
    step(1, C_LDMAR | C_INC, "R3 PC to MAR");
    step(2, C_LDIR | C_LDOUT, "R3 IR full byte");
    step(3, C_LDMAR, "R3 MAR");
    step(2, C_LDOUT, "R8 collision cell");

    // R1: reset mid-run, RAM retained
    step(0, 0, "R1 reset again", 1);
    show_a("R1 A cleared");
    step(1, C_LDOUT, "R1 PC cleared");
    step(2, C_LDOUT, "R1 RAM kept, MAR cleared");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule